// File: doc/BRIEF.md
# Decimator Host Control and Start Sequencer

This block sits between a host processor and the datapath of a two-stage decimating filter. The host writes configuration words over a 16-bit control bus using an active-low select, an active-low write strobe and a 2-bit slot address. The block captures each word into one of three configuration registers or hands it to the coefficient loader. The configuration registers hold the integrator/comb order, the input growth shift, the coarse-stage bypass, the coarse decimation rate, and the FIR bypass, disable and rate fields. The write strobe is not treated as a clock. The combined select-and-write condition is brought into the sample clock domain through a synchroniser, and the word is committed on the release of the strobe.

There are two ways to start the filter. An asynchronous request is synchronised and echoed as a one-period pulse, so several devices can be started on the same sample-clock edge. A synchronous start input starts the device when it goes from high to low. Once started, the block holds its run level until reset. While running, it drives a divider that strobes once every (rate + 1) sample clocks, which paces the decimated stages.

Top module: `decim_host_ctrl`

## Requirements
- R1: After reset, order, growth, coarse bypass, coarse rate, FIR bypass and FIR rate read 0, the FIR disable bit reads 1, and run, start_echo, dec_tick and coef_we read 0.
- R2: A write is sel_n and wr_n both low followed by wr_n rising while sel_n is still low. A write to slot 0 loads order from cbus[2:0], growth from cbus[8:3] and the coarse bypass from cbus[9]. The new values are visible no later than the fourth clock edge after wr_n rises.
- R3: A write to slot 1 loads the coarse decimation rate from cbus[9:0].
- R4: A write to slot 2 loads the FIR bypass from cbus[0], the FIR disable bit from cbus[1] and the FIR rate from cbus[5:2].
- R5: A write to slot 3 produces exactly one coef_we cycle carrying the written word on coef_wdata, and leaves every configuration register unchanged.
- R6: A wr_n pulse while sel_n stays high changes no register and produces no coef_we.
- R7: Each rising edge of arm_async gives exactly one start_echo pulse of one clock period. Holding arm_async high produces no further pulses.
- R8: A high-to-low transition of run_sync_in, sampled on the clock, sets run. A low-to-high transition does not set it.
- R9: Once set, run stays high until reset, whatever happens on the start inputs.
- R10: While run is high, dec_tick pulses once every (coarse rate + 1) clocks. While run is low, dec_tick stays low.
- R11: The start_echo pulse also sets run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select for host writes |
| wr_n | input | 1 | Active-low write strobe, commit on release |
| addr | input | 2 | Slot address: 0 order/growth, 1 coarse rate, 2 FIR control, 3 coefficient |
| cbus | input | 16 | Control data word |
| arm_async | input | 1 | Asynchronous start request |
| run_sync_in | input | 1 | Synchronous start, acts on falling edge |
| start_echo | output | 1 | One-period pulse from a synchronised start request |
| run | output | 1 | Sticky operating level, enables the divider |
| dec_tick | output | 1 | Decimation strobe from the divider |
| order | output | 3 | Number of active integrator/comb stages |
| growth | output | 6 | Input growth shift |
| hdf_byp | output | 1 | Coarse stage bypass |
| hrate | output | 10 | Coarse decimation rate minus one |
| fir_byp | output | 1 | FIR bypass |
| fir_off | output | 1 | FIR disable |
| frate | output | 4 | FIR decimation rate minus one |
| coef_we | output | 1 | Coefficient write strobe |
| coef_wdata | output | 16 | Coefficient word |

## Verification
The checks assume the host holds sel_n, addr and cbus steady from the strobe's fall until at least four clocks after wr_n rises, and keeps wr_n low for at least three clocks. These conditions let the synchroniser see every write and commit the word that was intended. The bench's write task keeps to these conditions on every write, including the one with sel_n high. Start inputs change only between clock edges. Divider periods are measured only after the rate write has settled and one tick has been skipped, so a rate change in the middle of a count does not affect the measured period.

// File: rtl/decim_ctrl_pkg.sv
package decim_ctrl_pkg;
    localparam int BUS_W     = 16;
    localparam int ADDR_W    = 2;
    localparam int ORDER_W   = 3;
    localparam int GROW_W    = 6;
    localparam int HRATE_W   = 10;
    localparam int FRATE_W   = 4;

    // field positions inside the written word
    localparam int ORDER_LSB = 0;
    localparam int GROW_LSB  = ORDER_LSB + ORDER_W;
    localparam int HBYP_BIT  = GROW_LSB + GROW_W;
    localparam int FBYP_BIT  = 0;
    localparam int FOFF_BIT  = 1;
    localparam int FRATE_LSB = 2;

    typedef enum logic [ADDR_W-1:0] {
        SLOT_ORDER  = 2'd0,
        SLOT_HRATE  = 2'd1,
        SLOT_FIRCTL = 2'd2,
        SLOT_COEF   = 2'd3
    } slot_e;

    typedef struct packed {
        logic [ORDER_W-1:0] order;
        logic [GROW_W-1:0]  growth;
        logic               hdf_byp;
        logic [HRATE_W-1:0] hrate;
        logic               fir_byp;
        logic               fir_off;
        logic [FRATE_W-1:0] frate;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        order:   '0,
        growth:  '0,
        hdf_byp: 1'b0,
        hrate:   '0,
        fir_byp: 1'b0,
        fir_off: 1'b1,
        frate:   '0
    };
endpackage

// File: rtl/ctrl_sync.sv
module ctrl_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] sh_d, sh_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_comb sh_d = din;
        end else begin : g_chain
            always_comb sh_d = {sh_q[DEPTH-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[DEPTH-1];
endmodule

// File: rtl/ctrl_regfile.sv
module ctrl_regfile
    import decim_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_s,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  cbus,
    output cfg_t              cfg,
    output logic              coef_we,
    output logic [BUS_W-1:0]  coef_wdata
);
    typedef struct packed {
        cfg_t             cfg;
        logic             act_prev;
        logic             coef_we;
        logic [BUS_W-1:0] coef_wdata;
    } rf_state_t;

    rf_state_t d, q;
    logic      commit;

    always_comb begin
        d          = q;
        d.act_prev = act_s;
        d.coef_we  = 1'b0;
        commit     = q.act_prev & ~act_s;
        if (commit) begin
            case (slot_e'(addr))
                SLOT_ORDER: begin
                    d.cfg.order   = cbus[ORDER_LSB +: ORDER_W];
                    d.cfg.growth  = cbus[GROW_LSB +: GROW_W];
                    d.cfg.hdf_byp = cbus[HBYP_BIT];
                end
                SLOT_HRATE: begin
                    d.cfg.hrate = cbus[HRATE_W-1:0];
                end
                SLOT_FIRCTL: begin
                    d.cfg.fir_byp = cbus[FBYP_BIT];
                    d.cfg.fir_off = cbus[FOFF_BIT];
                    d.cfg.frate   = cbus[FRATE_LSB +: FRATE_W];
                end
                default: begin
                    d.coef_we    = 1'b1;
                    d.coef_wdata = cbus;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cfg: CFG_RESET, act_prev: 1'b0, coef_we: 1'b0, coef_wdata: '0};
        else        q <= d;
    end

    assign cfg        = q.cfg;
    assign coef_we    = q.coef_we;
    assign coef_wdata = q.coef_wdata;
endmodule

// File: rtl/ctrl_start.sv
module ctrl_start (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_s,
    input  logic run_sync_in,
    output logic start_echo,
    output logic run
);
    typedef struct packed {
        logic arm_prev;
        logic sin_q;
        logic sin_prev;
        logic echo;
        logic run;
    } st_state_t;

    st_state_t d, q;
    logic      arm_rise, sin_fall;

    always_comb begin
        arm_rise   = arm_s & ~q.arm_prev;
        sin_fall   = q.sin_prev & ~q.sin_q;
        d          = q;
        d.arm_prev = arm_s;
        d.sin_q    = run_sync_in;
        d.sin_prev = q.sin_q;
        d.echo     = arm_rise;
        d.run      = q.run | arm_rise | sin_fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign start_echo = q.echo;
    assign run        = q.run;
endmodule

// File: rtl/ctrl_divider.sv
module ctrl_divider #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         tick
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         tick;
    } dv_state_t;

    dv_state_t d, q;
    logic      wrap;

    always_comb begin
        wrap = q.cnt >= limit;
        d    = q;
        if (!en) begin
            d.cnt  = '0;
            d.tick = 1'b0;
        end else begin
            d.tick = wrap;
            d.cnt  = wrap ? '0 : q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = q.tick;
endmodule

// File: rtl/decim_host_ctrl.sv
module decim_host_ctrl
    import decim_ctrl_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_n,
    input  logic               wr_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BUS_W-1:0]   cbus,
    input  logic               arm_async,
    input  logic               run_sync_in,
    output logic               start_echo,
    output logic               run,
    output logic               dec_tick,
    output logic [ORDER_W-1:0] order,
    output logic [GROW_W-1:0]  growth,
    output logic               hdf_byp,
    output logic [HRATE_W-1:0] hrate,
    output logic               fir_byp,
    output logic               fir_off,
    output logic [FRATE_W-1:0] frate,
    output logic               coef_we,
    output logic [BUS_W-1:0]   coef_wdata
);
    logic act_raw, act_s, arm_s;
    cfg_t cfg;

    assign act_raw = ~sel_n & ~wr_n;

    ctrl_sync #(.DEPTH(SYNC_DEPTH)) u_wsync (
        .clk(clk), .rst_n(rst_n), .din(act_raw), .dout(act_s)
    );

    ctrl_sync #(.DEPTH(SYNC_DEPTH)) u_async (
        .clk(clk), .rst_n(rst_n), .din(arm_async), .dout(arm_s)
    );

    ctrl_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .act_s(act_s), .addr(addr), .cbus(cbus),
        .cfg(cfg), .coef_we(coef_we), .coef_wdata(coef_wdata)
    );

    ctrl_start u_start (
        .clk(clk), .rst_n(rst_n), .arm_s(arm_s), .run_sync_in(run_sync_in),
        .start_echo(start_echo), .run(run)
    );

    ctrl_divider #(.W(HRATE_W)) u_div (
        .clk(clk), .rst_n(rst_n), .en(run), .limit(cfg.hrate), .tick(dec_tick)
    );

    assign order   = cfg.order;
    assign growth  = cfg.growth;
    assign hdf_byp = cfg.hdf_byp;
    assign hrate   = cfg.hrate;
    assign fir_byp = cfg.fir_byp;
    assign fir_off = cfg.fir_off;
    assign frate   = cfg.frate;
endmodule

// File: rtl/decim_host_ctrl_chk.sv
module decim_host_ctrl_chk
    import decim_ctrl_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               start_echo,
    input logic               run,
    input logic               dec_tick,
    input logic [ORDER_W-1:0] order,
    input logic [HRATE_W-1:0] hrate,
    input logic               fir_off,
    input logic [FRATE_W-1:0] frate,
    input logic               coef_we
);
    assert_echo_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_echo |=> !start_echo);

    assert_echo_runs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_echo |-> run);

    assert_run_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> run);

    assert_tick_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_tick |-> run);

    assert_coef_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        coef_we |=> !coef_we);

    assert_coef_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        coef_we |-> ($stable(hrate) && $stable(order) && $stable(fir_off) && $stable(frate)));
endmodule

bind decim_host_ctrl decim_host_ctrl_chk u_chk (.*);

// File: tb/sim_decim_host_ctrl.sv
`timescale 1ns/1ps
module sim_decim_host_ctrl;
    logic        clk = 1'b0;
    logic        rst_n, sel_n, wr_n, arm_async, run_sync_in;
    logic [1:0]  addr;
    logic [15:0] cbus;
    logic        start_echo, run, dec_tick, hdf_byp, fir_byp, fir_off, coef_we;
    logic [2:0]  order;
    logic [5:0]  growth;
    logic [9:0]  hrate;
    logic [3:0]  frate;
    logic [15:0] coef_wdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [15:0] exp_coef[$];

    always #2.5 clk = ~clk;

    decim_host_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .addr(addr), .cbus(cbus),
        .arm_async(arm_async), .run_sync_in(run_sync_in), .start_echo(start_echo),
        .run(run), .dec_tick(dec_tick), .order(order), .growth(growth), .hdf_byp(hdf_byp),
        .hrate(hrate), .fir_byp(fir_byp), .fir_off(fir_off), .frate(frate),
        .coef_we(coef_we), .coef_wdata(coef_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: compare every coefficient strobe against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && coef_we === 1'b1) begin
            if (exp_coef.size() == 0) chk("R5 unexpected coef_we", 32'd1, 32'd0);
            else chk("R5 coef_wdata", {16'd0, coef_wdata}, {16'd0, exp_coef.pop_front()});
        end
    end

    task automatic host_write(input logic cs_low, input logic [1:0] a, input logic [15:0] w);
        @(negedge clk);
        sel_n = ~cs_low;
        addr  = a;
        cbus  = w;
        wr_n  = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        sel_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic tick_gap(output int gap);
        int w = 0;
        while (dec_tick !== 1'b1 && w < 2000) begin @(negedge clk); w++; end
        @(negedge clk);
        gap = 1;
        while (dec_tick !== 1'b1 && gap < 2000) begin @(negedge clk); gap++; end
    endtask

    task automatic measure(input string req, input int expect_gap);
        int g;
        tick_gap(g);   // skip the tick that may straddle the rate change
        tick_gap(g);
        chk(req, g, expect_gap);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        sel_n = 1'b1; wr_n = 1'b1; addr = '0; cbus = '0;
        arm_async = 1'b0; run_sync_in = 1'b0;
        do_reset();

        // R1 reset values
        chk("R1 order", order, 0);
        chk("R1 growth", growth, 0);
        chk("R1 hdf_byp", hdf_byp, 0);
        chk("R1 hrate", hrate, 0);
        chk("R1 fir_byp", fir_byp, 0);
        chk("R1 fir_off", fir_off, 1);
        chk("R1 frate", frate, 0);
        chk("R1 run", run, 0);
        chk("R1 start_echo", start_echo, 0);
        chk("R1 dec_tick", dec_tick, 0);
        chk("R1 coef_we", coef_we, 0);

        // R2 slot 0
        host_write(1'b1, 2'd0, 16'h0355);
        chk("R2 order", order, 5);
        chk("R2 growth", growth, 6'h2A);
        chk("R2 hdf_byp", hdf_byp, 1);

        // R3 slot 1
        host_write(1'b1, 2'd1, 16'h03FF);
        chk("R3 hrate", hrate, 10'h3FF);

        // R4 slot 2
        host_write(1'b1, 2'd2, 16'h002D);
        chk("R4 fir_byp", fir_byp, 1);
        chk("R4 fir_off", fir_off, 0);
        chk("R4 frate", frate, 4'hB);

        // R5 slot 3: scoreboard entry, registers untouched
        exp_coef.push_back(16'hBEEF);
        host_write(1'b1, 2'd3, 16'hBEEF);
        chk("R5 hrate kept", hrate, 10'h3FF);
        chk("R5 order kept", order, 5);
        chk("R5 frate kept", frate, 4'hB);
        chk("R5 queue drained", exp_coef.size(), 0);

        // R6 strobe without select
        host_write(1'b0, 2'd1, 16'h0001);
        chk("R6 hrate kept", hrate, 10'h3FF);
        host_write(1'b0, 2'd3, 16'h1234);

        // R8 rising edge of sync start does nothing, falling edge starts
        run_sync_in = 1'b1;
        repeat (5) @(negedge clk);
        chk("R8 no start on rise", run, 0);
        run_sync_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 start on fall", run, 1);
        chk("R8 no echo from sync start", start_echo, 0);

        // R10 divider periods
        host_write(1'b1, 2'd1, 16'd3);
        measure("R10 period rate 3", 4);
        host_write(1'b1, 2'd1, 16'd0);
        measure("R10 period rate 0", 1);
        host_write(1'b1, 2'd1, 16'd6);
        measure("R10 period rate 6", 7);

        // R9 sticky run
        run_sync_in = 1'b1;
        repeat (4) @(negedge clk);
        run_sync_in = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 run stays", run, 1);

        // R1 again after a second reset, R10 idle
        do_reset();
        chk("R1 run after reset", run, 0);
        chk("R1 fir_off after reset", fir_off, 1);
        chk("R1 hrate after reset", hrate, 0);
        begin
            int cnt = 0;
            for (int i = 0; i < 20; i++) begin @(negedge clk); if (dec_tick) cnt++; end
            chk("R10 no tick while idle", cnt, 0);
        end

        // R7 / R11 asynchronous start
        begin
            int cnt = 0;
            arm_async = 1'b1;
            for (int i = 0; i < 12; i++) begin @(negedge clk); if (start_echo) cnt++; end
            chk("R7 one echo per request", cnt, 1);
            chk("R11 echo sets run", run, 1);
            cnt = 0;
            for (int i = 0; i < 10; i++) begin @(negedge clk); if (start_echo) cnt++; end
            chk("R7 held request no repeat", cnt, 0);
            arm_async = 1'b0;
            repeat (5) @(negedge clk);
            arm_async = 1'b1;
            cnt = 0;
            for (int i = 0; i < 12; i++) begin @(negedge clk); if (start_echo) cnt++; end
            chk("R7 second request echoes", cnt, 1);
        end

        chk("R5 scoreboard empty", exp_coef.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule